// File: doc/BRIEF.md
# Configurable SPI Serial Port

This block is a byte-wide SPI port that a host processor controls through three registers on a simple synchronous bus: a control register, a status register and a data register. It can act as the clock-driving side of a link (master) or as the clocked side (slave). Clock polarity, clock phase and bit order can each be set either way, and in master mode a four-step divider sets the serial clock rate.

In master mode, a write to the data register while the port is idle loads the byte and shifts it out over eight serial clock periods, while the byte arriving on MISO is collected. In slave mode, the external serial clock, slave select and MOSI first pass through a two-stage synchronizer into the system clock domain. The slave shifts only while its select is low, and it drives MISO only in that window. When a byte completes, a done flag is raised, and that flag can drive an interrupt. A write to the data register during a transfer is dropped and raises a collision flag. Both flags are cleared by a two-step handshake: a status read taken while a flag is set, followed by an access to the data register.

Top module: `spi_port`

## Requirements
- R1: After reset the control byte, both flags, and the received-data byte all read 0. `sck_o` and `mosi_o` are 0, and `miso_oe` and `irq` are 0.
- R2: Register select 0 reads and writes the control byte, with bit 7 interrupt enable, bit 6 port enable, bit 5 LSB-first, bit 4 master, bit 3 CPOL, bit 2 CPHA and bits 1:0 rate. Select 1 reads status, with bit 7 the done flag, bit 6 the collision flag and all other bits 0. Select 2 is the data register. Select 3 reads 0.
- R3: In master mode with the port enabled and idle, a data write starts an 8-bit transfer. The done flag becomes visible 16×(N/2) clock cycles after the clock edge that accepted the write, where N is the divide ratio.
- R4: Rate codes 00, 01, 10 and 11 give a master SCK of the system clock divided by 4, 16, 64 and 128. Each SCK level lasts N/2 cycles. In slave mode the rate code has no effect.
- R5: With LSB-first set, bit 0 is shifted first on both data lines. Otherwise bit 7 is shifted first.
- R6: SCK idles at the CPOL level. With CPHA=0, data is sampled on the leading SCK edges and changes on the trailing edges. With CPHA=1, data changes on the leading edges (from the second one on) and is sampled on the trailing edges.
- R7: `irq` is 1 exactly when the done flag, the interrupt enable bit and `glb_irq_en` are all 1.
- R8: A data write while a transfer is in progress sets the collision flag. The written byte is discarded, and the transfer carries on with the original byte and timing.
- R9: A status read taken while either flag is set, followed later by any data-register read or write, clears both flags. A data access without that earlier status read leaves the flags unchanged.
- R10: If a flag-setting event (completion or collision) falls in the same cycle as the clearing data access, that flag ends up set.
- R11: With port enable 0, a data write starts nothing, sets no flag and is dropped. SCK stays at CPOL and MOSI stays at 0. Clearing port enable during a transfer aborts it without setting the done flag.
- R12: In slave mode the slave select, SCK and MOSI inputs pass through two synchronizer stages. The slave shifts only while the synchronized select is low. `miso_oe` is 1 only while the port is enabled in slave mode with select low. A data write while the slave is idle preloads the byte to be sent.
- R13: A data-register read returns the last fully received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| rd_en | input | 1 | Read strobe for the selected register |
| wr_en | input | 1 | Write strobe for the selected register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register (combinational) |
| glb_irq_en | input | 1 | System-level serial interrupt enable |
| irq | output | 1 | Transfer-complete interrupt |
| sck_i | input | 1 | Serial clock from an external master (slave mode) |
| sck_o | output | 1 | Serial clock driven in master mode |
| mosi_i | input | 1 | Serial data in (slave mode) |
| mosi_o | output | 1 | Serial data out (master mode) |
| miso_i | input | 1 | Serial data in (master mode) |
| miso_o | output | 1 | Serial data out (slave mode) |
| miso_oe | output | 1 | Output enable for `miso_o` |
| ss_n | input | 1 | Active-low slave select (slave mode) |

## Verification
The clearing handshake and the setting of a flag can land on the same clock edge. The bench provokes this deliberately. During a master transfer it writes the data register to raise a collision, then reads status to arm the clear. It then times a data-register read for the final busy cycle, so that the access coincides with completion. The expected result is a status byte showing only the done flag: the collision is cleared and the completion survives. One cycle earlier, the status must still show done as 0.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int BYTE_W = 8;
    localparam int EDGE_N = 2 * BYTE_W;
    localparam int EDGE_W = $clog2(EDGE_N);
    localparam int DIV_W  = 6;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       irq_en;
        logic       port_en;
        logic       lsb_first;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    typedef struct packed {
        ctrl_t              ctrl;
        logic               done;
        logic               coll;
        logic               armed;
        logic               busy;
        logic [EDGE_W-1:0]  edge_cnt;
        logic               sck;
        logic               sck_prev;
        logic [BYTE_W-1:0]  tx;
        logic [BYTE_W-1:0]  rx;
        logic [BYTE_W-1:0]  rdbuf;
    } port_st_t;

    // Cycles per SCK level minus one: the divide ratio is 4, 16, 64 or 128
    function automatic logic [DIV_W-1:0] half_period_m1(input logic [1:0] rate);
        logic [DIV_W:0] half;
        logic [DIV_W:0] hm1;
        half = (rate == 2'b11) ? (DIV_W+1)'(64) : ((DIV_W+1)'(2) << (2 * rate));
        hm1  = half - 1'b1;
        return hm1[DIV_W-1:0];
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb stage_d = din;
        end else begin : g_chain
            always_comb stage_d = {stage_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= {STAGES{RST_VAL}};
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == limit);
        cnt_d = cnt_q + 1'b1;
        if (!run || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_sel,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       glb_irq_en,
    output logic       irq,
    input  logic       sck_i,
    output logic       sck_o,
    input  logic       mosi_i,
    output logic       mosi_o,
    input  logic       miso_i,
    output logic       miso_o,
    output logic       miso_oe,
    input  logic       ss_n
);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGE_N - 1);

    port_st_t st_d, st_q;

    logic       ss_s, sck_s, mosi_s;
    logic       tick;
    logic       mst, slv, slv_sel;
    logic       ctrl_wr, stat_rd, dat_wr, data_acc;
    logic       edge_ev, sample_ev, shift_ev, last_ev;
    logic       coll_set, clr, in_bit, out_bit;

    // external serial inputs, brought into the clock domain
    spi_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ss_n, sck_i, mosi_i}),
        .dout  ({ss_s, sck_s, mosi_s})
    );

    spi_clkdiv #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.busy && mst),
        .limit (half_period_m1(st_q.ctrl.rate)),
        .tick  (tick)
    );

    always_comb begin
        st_d = st_q;

        mst     = st_q.ctrl.port_en && st_q.ctrl.master;
        slv     = st_q.ctrl.port_en && !st_q.ctrl.master;
        slv_sel = slv && !ss_s;

        ctrl_wr  = wr_en && (reg_sel_e'(reg_sel) == SEL_CTRL);
        stat_rd  = rd_en && (reg_sel_e'(reg_sel) == SEL_STAT);
        dat_wr   = wr_en && (reg_sel_e'(reg_sel) == SEL_DATA);
        data_acc = (rd_en || wr_en) && (reg_sel_e'(reg_sel) == SEL_DATA);

        // edge events: divider in master mode, observed SCK change in slave mode
        edge_ev   = mst ? (st_q.busy && tick) : (slv_sel && (sck_s != st_q.sck_prev));
        sample_ev = edge_ev && (st_q.edge_cnt[0] == st_q.ctrl.cpha);
        shift_ev  = edge_ev && (st_q.edge_cnt[0] != st_q.ctrl.cpha)
                    && !(st_q.ctrl.cpha && (st_q.edge_cnt == '0));
        last_ev   = edge_ev && (st_q.edge_cnt == LAST_EDGE);

        in_bit  = mst ? miso_i : mosi_s;
        out_bit = st_q.ctrl.lsb_first ? st_q.tx[0] : st_q.tx[BYTE_W-1];

        st_d.sck_prev = sck_s;

        if (sample_ev)
            st_d.rx = st_q.ctrl.lsb_first ? {in_bit, st_q.rx[BYTE_W-1:1]}
                                          : {st_q.rx[BYTE_W-2:0], in_bit};
        if (shift_ev)
            st_d.tx = st_q.ctrl.lsb_first ? (st_q.tx >> 1) : (st_q.tx << 1);

        if (edge_ev) begin
            st_d.edge_cnt = st_q.edge_cnt + 1'b1;
            st_d.busy     = 1'b1;
            if (mst) st_d.sck = ~st_q.sck;
        end
        if (last_ev) begin
            st_d.busy     = 1'b0;
            st_d.edge_cnt = '0;
            st_d.rdbuf    = st_d.rx;
        end

        // data write: start or preload when idle, collision when busy
        coll_set = dat_wr && st_q.ctrl.port_en && st_q.busy;
        if (dat_wr && st_q.ctrl.port_en && !st_q.busy) begin
            st_d.tx = wdata;
            if (mst) begin
                st_d.busy     = 1'b1;
                st_d.edge_cnt = '0;
                st_d.sck      = st_q.ctrl.cpol;
            end
        end

        // slave deselected or port disabled: drop any partial byte
        if ((slv && ss_s) || !st_q.ctrl.port_en) begin
            st_d.busy     = 1'b0;
            st_d.edge_cnt = '0;
        end

        if (ctrl_wr) st_d.ctrl = ctrl_t'(wdata);

        // flag handshake; a set in the same cycle overrides the clear
        clr = st_q.armed && data_acc;
        if (clr) begin
            st_d.done  = 1'b0;
            st_d.coll  = 1'b0;
            st_d.armed = 1'b0;
        end
        if (stat_rd && (st_q.done || st_q.coll)) st_d.armed = 1'b1;
        if (last_ev)  st_d.done = 1'b1;
        if (coll_set) st_d.coll = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_sel_e'(reg_sel))
            SEL_CTRL: rdata = st_q.ctrl;
            SEL_STAT: rdata = {st_q.done, st_q.coll, 6'b0};
            SEL_DATA: rdata = st_q.rdbuf;
            default:  rdata = '0;
        endcase
    end

    assign sck_o   = (mst && st_q.busy) ? st_q.sck : st_q.ctrl.cpol;
    assign mosi_o  = (mst && st_q.busy) ? out_bit : 1'b0;
    assign miso_o  = slv_sel ? out_bit : 1'b0;
    assign miso_oe = slv_sel;
    assign irq     = st_q.done && st_q.ctrl.irq_en && glb_irq_en;

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
    input logic clk,
    input logic rst_n,
    input logic port_en,
    input logic cpol,
    input logic busy,
    input logic done,
    input logic coll,
    input logic armed,
    input logic ss_s,
    input logic sck_o,
    input logic miso_oe,
    input logic irq,
    input logic glb_irq_en,
    input logic dat_wr,
    input logic data_acc,
    input logic last_ev
);
    assert_idle_sck_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> (sck_o == cpol));

    assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !busy);

    assert_miso_hiz_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ss_s |-> !miso_oe);

    assert_coll_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && busy && port_en) |=> coll);

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && data_acc && !last_ev && !(dat_wr && busy && port_en)) |=> (!done && !coll));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && data_acc && done) |=> done);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && data_acc && last_ev) |=> done);

    assert_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done && glb_irq_en));
endmodule

bind spi_port spi_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_en    (st_q.ctrl.port_en),
    .cpol       (st_q.ctrl.cpol),
    .busy       (st_q.busy),
    .done       (st_q.done),
    .coll       (st_q.coll),
    .armed      (st_q.armed),
    .ss_s       (ss_s),
    .sck_o      (sck_o),
    .miso_oe    (miso_oe),
    .irq        (irq),
    .glb_irq_en (glb_irq_en),
    .dat_wr     (dat_wr),
    .data_acc   (data_acc),
    .last_ev    (last_ev)
);

// File: tb/spi_port_test.sv
`timescale 1ns/100ps
module spi_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd3;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic       glb_irq_en = 1'b0, irq;
    logic       sck_i = 1'b0, sck_o, mosi_i = 1'b0, mosi_o;
    logic       miso_i = 1'b0, miso_o, miso_oe, ss_n = 1'b1;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    spi_port uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .glb_irq_en(glb_irq_en), .irq(irq),
        .sck_i(sck_i), .sck_o(sck_o), .mosi_i(mosi_i), .mosi_o(mosi_o),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n(ss_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic peek(input logic [1:0] s, output logic [7:0] v);
        reg_sel = s;
        #0.5;
        v = rdata;
    endtask

    task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] s);
        @(negedge clk);
        reg_sel = s; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic int bitpos(input int k, input logic lsb);
        return lsb ? k : 7 - k;
    endfunction

    // master transfer with a cycle-by-cycle expectation of SCK, irq and completion
    task automatic master_xfer(input logic cpol, input logic cpha, input logic lsb,
                               input logic [1:0] rate, input logic [7:0] tx,
                               input logic [7:0] rxb, input logic glb,
                               input int coll_at, input int arm_at, input int read_at);
        int h;
        int total;
        int sd;
        logic [7:0] cap;
        logic [7:0] v;
        logic       exp_coll;
        h = (rate == 2'b11) ? 64 : (2 << (2 * rate));
        total = 16 * h;
        cap = '0;
        glb_irq_en = glb;
        bus_wr(2'd0, {1'b1, 1'b1, lsb, 1'b1, cpol, cpha, rate});
        bus_rd(2'd1);
        @(negedge clk);
        reg_sel = 2'd2; wdata = tx; wr_en = 1'b1;
        miso_i = rxb[bitpos(0, lsb)];
        for (int c = 0; c < total; c++) begin
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0;
            sd = cpha ? (c / h) / 2 : ((c / h) + 1) / 2;
            miso_i = rxb[bitpos((sd > 7) ? 7 : sd, lsb)];
            chk("R4 R6 sck level", int'(sck_o), int'(cpol ^ logic'((c / h) % 2)));
            chk("R7 irq low while busy", int'(irq), 0);
            if ((c % h) == h - 1 && ((c / h) % 2) == int'(cpha))
                cap[bitpos(sd, lsb)] = mosi_o;
            if (c == total - 1) begin
                peek(2'd1, v);
                chk("R3 done not yet set in last busy cycle", int'(v[7]), 0);
            end
            if (c == coll_at) begin reg_sel = 2'd2; wdata = ~tx; wr_en = 1'b1; end
            if (c == arm_at)  begin reg_sel = 2'd1; rd_en = 1'b1; end
            if (c == read_at) begin reg_sel = 2'd2; rd_en = 1'b1; end
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        exp_coll = (coll_at >= 0) && !(arm_at > coll_at && read_at > arm_at);
        peek(2'd1, v);
        chk("R3 R8 R10 status after transfer", int'(v), int'({1'b1, exp_coll, 6'b0}));
        peek(2'd2, v);
        chk("R13 R5 received byte", int'(v), int'(rxb));
        chk("R5 R6 R8 bits seen on MOSI", int'(cap), int'(tx));
        chk("R7 irq after completion", int'(irq), int'(glb));
        chk("R6 sck back at idle", int'(sck_o), int'(cpol));
    endtask

    task automatic slave_xfer(input logic cpol, input logic cpha, input logic lsb,
                              input logic [7:0] tx, input logic [7:0] rxb);
        int hp;
        int m;
        int ks;
        logic [7:0] cap;
        logic [7:0] v;
        hp = 8; m = 0; ks = 0; cap = '0;
        ss_n = 1'b1; sck_i = cpol;
        bus_wr(2'd0, {1'b0, 1'b1, lsb, 1'b0, cpol, cpha, 2'b11});
        repeat (4) @(negedge clk);
        chk("R12 miso released while deselected", int'(miso_oe), 0);
        bus_rd(2'd1);
        bus_wr(2'd2, tx);
        ss_n = 1'b0;
        mosi_i = rxb[bitpos(0, lsb)];
        repeat (hp) @(negedge clk);
        chk("R12 miso driven while selected", int'(miso_oe), 1);
        for (int e = 0; e < 16; e++) begin
            if ((e % 2) == int'(cpha)) begin
                cap[bitpos(ks, lsb)] = miso_o;
                ks++;
            end
            sck_i = ~sck_i;
            if ((e % 2) != int'(cpha) && !(cpha && e == 0)) begin
                m++;
                if (m < 8) mosi_i = rxb[bitpos(m, lsb)];
            end
            repeat (hp) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        peek(2'd1, v);
        chk("R12 R4 slave done flag", int'(v), 8'h80);
        peek(2'd2, v);
        chk("R12 R13 slave received byte", int'(v), int'(rxb));
        chk("R12 R5 slave bits on MISO", int'(cap), int'(tx));
        chk("R7 irq off with enable bit clear", int'(irq), 0);
        ss_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R12 miso released after deselect", int'(miso_oe), 0);
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(2'd0, v); chk("R1 control after reset", int'(v), 0);
        peek(2'd1, v); chk("R1 status after reset", int'(v), 0);
        peek(2'd2, v); chk("R1 data after reset", int'(v), 0);
        chk("R1 sck_o after reset", int'(sck_o), 0);
        chk("R1 mosi_o after reset", int'(mosi_o), 0);
        chk("R1 miso_oe after reset", int'(miso_oe), 0);
        chk("R1 irq after reset", int'(irq), 0);

        // R2 control readback and unused select
        bus_wr(2'd0, 8'h4B);
        peek(2'd0, v); chk("R2 control readback", int'(v), 8'h4B);
        peek(2'd3, v); chk("R2 select 3 reads zero", int'(v), 0);

        // R11 disabled port ignores data write
        bus_wr(2'd0, 8'h18);
        bus_wr(2'd2, 8'h5A);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sck_o !== 1'b1 || mosi_o !== 1'b0) bad++;
        end
        chk("R11 lines idle while disabled", bad, 0);
        peek(2'd1, v); chk("R11 no flag from disabled write", int'(v), 0);
        peek(2'd2, v); chk("R11 R13 data unchanged by disabled write", int'(v), 0);

        // R11 abort by clearing port enable mid-transfer
        bus_wr(2'd0, 8'h50);
        bus_wr(2'd2, 8'hFF);
        repeat (3) @(negedge clk);
        bus_wr(2'd0, 8'h10);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sck_o !== 1'b0 || mosi_o !== 1'b0) bad++;
        end
        chk("R11 lines idle after abort", bad, 0);
        peek(2'd1, v); chk("R11 no done after abort", int'(v), 0);

        // master transfers over modes and rates
        master_xfer(1'b0, 1'b0, 1'b0, 2'b00, 8'hA5, 8'h3C, 1'b1, -1, -1, -1);
        master_xfer(1'b1, 1'b1, 1'b1, 2'b01, 8'h96, 8'hE1, 1'b1, -1, -1, -1);
        master_xfer(1'b0, 1'b1, 1'b0, 2'b10, 8'h5B, 8'hC4, 1'b0, -1, -1, -1);
        master_xfer(1'b1, 1'b0, 1'b1, 2'b11, 8'h0F, 8'h81, 1'b1, -1, -1, -1);

        // R9 data access without status read leaves flags
        bus_rd(2'd2);
        peek(2'd1, v); chk("R9 flag kept without status read", int'(v), 8'h80);
        bus_rd(2'd1);
        bus_rd(2'd2);
        peek(2'd1, v); chk("R9 flags cleared by handshake", int'(v), 0);
        chk("R7 irq drops with flag", int'(irq), 0);

        // R8 collision during transfer
        master_xfer(1'b0, 1'b0, 1'b0, 2'b00, 8'h33, 8'h44, 1'b1, 5, -1, -1);
        // R10 clearing access in the completion cycle
        master_xfer(1'b0, 1'b0, 1'b0, 2'b01, 8'hC6, 8'h29, 1'b1, 10, 20, 127);

        // R12 slave transfers, rate bits set to 11 and ignored (R4)
        slave_xfer(1'b0, 1'b0, 1'b0, 8'hC3, 8'h5A);
        slave_xfer(1'b1, 1'b1, 1'b1, 8'h18, 8'hE7);

        summary();
        $finish;
    end
endmodule